// File: doc/BRIEF.md
# Receive Byte Slip Buffer

This block carries bytes from a recovered-clock receive path into one chosen 8-bit time-slot of a 2.048 Mbit/s PCM output stream. Whole bytes arrive as a byte value with a one-cycle valid strobe. A pair of byte registers is written alternately, so the pair behaves as an elastic store one frame deep. At the start of every selected time-slot the read side takes the most recently completed register. It then shifts that byte out serially, most significant bit first, over eight clock cycles.

When the write and read rates drift apart, the block resolves the slip on whole bytes. It repeats the previous byte when nothing new has arrived, or skips the older of two or more unread bytes. A one-cycle flag reports each repetition and each skip. Two time-slot strobe inputs are provided, and a select input picks the one that is used. The output can be forced to all ones in two ways: directly, or when the receive alarm is raised while supervision is enabled.

Top module: `rx_slip_buffer`

## Requirements
- R1: After reset, `pcm_out` is 1 and both flags are 0. Both byte registers hold 0xFF, so the first slot after reset with no byte written outputs 0xFF and raises `ins_flag`.
- R2: If exactly one byte was written since the previous slot start, the next slot outputs that byte. The selected strobe is sampled high at edge T. `pcm_out` then carries bit 7 after edge T and bits 6 down to 0 after edges T+1 through T+7.
- R3: When `slot_sel` = 1, only `slot_a` starts a slot. When `slot_sel` = 0, only `slot_b` starts a slot. A pulse on the strobe that is not selected leaves `pcm_out` high and the flags low.
- R4: If no byte was written since the previous slot start, the previous byte is output again. `ins_flag` is 1 for exactly the cycle after edge T.
- R5: If two or more bytes were written since the previous slot start, only the newest is output. `del_flag` is 1 for exactly the cycle after edge T. `ins_flag` and `del_flag` are never 1 together.
- R6: A byte written in the same cycle as a slot start is not read by that slot. It counts toward the next slot.
- R7: When `blank` is 1 at an edge, `pcm_out` is 1 after that edge.
- R8: When `sup_n` is 0 and `alarm` is 1 at an edge, `pcm_out` is 1 after that edge. Either condition alone has no effect.
- R9: Outside the eight bit periods of a slot, `pcm_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz receive bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | One-cycle strobe: `byte_in` holds a complete byte |
| byte_in | input | 8 | Received byte |
| slot_a | input | 1 | Time-slot start strobe A |
| slot_b | input | 1 | Time-slot start strobe B |
| slot_sel | input | 1 | 1 selects `slot_a`, 0 selects `slot_b` |
| blank | input | 1 | Force output to all ones, active high |
| sup_n | input | 1 | Supervision enable, active low |
| alarm | input | 1 | Receive alarm, active high |
| pcm_out | output | 1 | Serial PCM output, idles high |
| ins_flag | output | 1 | One-cycle pulse: byte repeated |
| del_flag | output | 1 | One-cycle pulse: byte dropped |

## Verification
The buffer is driven with three write patterns between slot starts: zero writes, exactly one write, and two writes. These patterns separate the normal path from the repeat path and the skip path. Each one is identified by the byte that appears and by which flag pulses. A write placed in the same cycle as a slot start shows whether that write is hidden from the current read. Strobes are pulsed on the selected and the unselected input, which shows the selection works. The two blanking causes are applied alone and in combination in the middle of a byte, which separates forcing from normal serial data.

// File: rtl/rx_slip_pkg.sv
package rx_slip_pkg;
    parameter int BYTE_W = 8;
    parameter int NREG   = 2;
    localparam int IDX_W  = $clog2(NREG);
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [1:0]        pend_t;   // saturating count of unread writes: 0, 1, 2+
    typedef logic [CNT_W-1:0]  left_t;
endpackage

// File: rtl/rx_slip_store.sv
module rx_slip_store
    import rx_slip_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_vld,
    input  byte_t wr_data,
    input  logic  rd_take,
    input  idx_t  rd_idx,
    output byte_t rd_data,
    output idx_t  last_idx,
    output pend_t pend_cnt
);
    typedef struct packed {
        idx_t  wr_ptr;
        idx_t  last;
        pend_t pend;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    byte_t bank_q [NREG];

    always_comb begin
        ctl_d = ctl_q;
        if (wr_vld) begin
            ctl_d.last   = ctl_q.wr_ptr;
            ctl_d.wr_ptr = ctl_q.wr_ptr + idx_t'(1);
        end
        if (rd_take) begin
            ctl_d.pend = wr_vld ? pend_t'(1) : pend_t'(0);
        end else if (wr_vld && ctl_q.pend != 2'd2) begin
            ctl_d.pend = ctl_q.pend + pend_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_bank
        byte_t bank_d;
        always_comb begin
            bank_d = bank_q[g];
            if (wr_vld && ctl_q.wr_ptr == idx_t'(g)) bank_d = wr_data;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bank_q[g] <= '1;
            else        bank_q[g] <= bank_d;
        end
    end

    assign rd_data  = bank_q[rd_idx];
    assign last_idx = ctl_q.last;
    assign pend_cnt = ctl_q.pend;
endmodule

// File: rtl/rx_slip_select.sv
module rx_slip_select
    import rx_slip_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  pend_t pend_cnt,
    input  idx_t  last_idx,
    output idx_t  rd_idx,
    output logic  ins_flag,
    output logic  del_flag
);
    typedef struct packed {
        idx_t sel;
        logic ins;
        logic del;
    } sel_t;

    sel_t sel_d, sel_q;
    idx_t pick;

    always_comb begin
        pick  = (pend_cnt == 2'd0) ? sel_q.sel : last_idx;
        sel_d = sel_q;
        sel_d.ins = 1'b0;
        sel_d.del = 1'b0;
        if (start) begin
            sel_d.sel = pick;
            sel_d.ins = (pend_cnt == 2'd0);
            sel_d.del = (pend_cnt == 2'd2);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign rd_idx   = pick;
    assign ins_flag = sel_q.ins;
    assign del_flag = sel_q.del;
endmodule

// File: rtl/rx_slip_serial.sv
module rx_slip_serial
    import rx_slip_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  byte_t load_data,
    input  logic  force_one,
    output logic  pcm_out,
    output left_t bits_left
);
    typedef struct packed {
        byte_t sh;
        left_t left;
        logic  pcm;
    } ser_t;

    ser_t ser_d, ser_q;
    logic bit_v;

    always_comb begin
        ser_d = ser_q;
        bit_v = 1'b1;
        if (load) begin
            bit_v      = load_data[BYTE_W-1];
            ser_d.sh   = load_data << 1;
            ser_d.left = left_t'(BYTE_W - 1);
        end else if (ser_q.left != '0) begin
            bit_v      = ser_q.sh[BYTE_W-1];
            ser_d.sh   = ser_q.sh << 1;
            ser_d.left = ser_q.left - left_t'(1);
        end
        ser_d.pcm = force_one ? 1'b1 : bit_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ser_q <= '{sh: '1, left: '0, pcm: 1'b1};
        else        ser_q <= ser_d;
    end

    assign pcm_out   = ser_q.pcm;
    assign bits_left = ser_q.left;
endmodule

// File: rtl/rx_slip_buffer.sv
module rx_slip_buffer
    import rx_slip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    input  logic       slot_a,
    input  logic       slot_b,
    input  logic       slot_sel,
    input  logic       blank,
    input  logic       sup_n,
    input  logic       alarm,
    output logic       pcm_out,
    output logic       ins_flag,
    output logic       del_flag
);
    logic  slot_start;
    logic  force_one;
    idx_t  rd_idx;
    idx_t  last_idx;
    pend_t pend_cnt;
    byte_t rd_data;
    left_t bits_left;

    assign slot_start = slot_sel ? slot_a : slot_b;
    assign force_one  = blank | (~sup_n & alarm);

    rx_slip_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_vld   (byte_vld),
        .wr_data  (byte_in),
        .rd_take  (slot_start),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .last_idx (last_idx),
        .pend_cnt (pend_cnt)
    );

    rx_slip_select u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (slot_start),
        .pend_cnt (pend_cnt),
        .last_idx (last_idx),
        .rd_idx   (rd_idx),
        .ins_flag (ins_flag),
        .del_flag (del_flag)
    );

    rx_slip_serial u_serial (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (slot_start),
        .load_data (rd_data),
        .force_one (force_one),
        .pcm_out   (pcm_out),
        .bits_left (bits_left)
    );
endmodule

// File: rtl/rx_slip_buffer_chk.sv
module rx_slip_buffer_chk
    import rx_slip_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  blank,
    input logic  sup_n,
    input logic  alarm,
    input logic  slot_start,
    input pend_t pend_cnt,
    input left_t bits_left,
    input logic  pcm_out,
    input logic  ins_flag,
    input logic  del_flag
);
    // R5
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_flag && del_flag));

    // R4
    ins_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_flag |-> ($past(slot_start) && $past(pend_cnt) == 2'd0));

    // R5
    del_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        del_flag |-> ($past(slot_start) && $past(pend_cnt) == 2'd2));

    // R7
    blank_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(blank) |-> pcm_out);

    // R8
    alarm_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alarm) && !$past(sup_n)) |-> pcm_out);

    // R9
    idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(slot_start) && $past(bits_left) == '0) |-> pcm_out);
endmodule

bind rx_slip_buffer rx_slip_buffer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .blank      (blank),
    .sup_n      (sup_n),
    .alarm      (alarm),
    .slot_start (slot_start),
    .pend_cnt   (pend_cnt),
    .bits_left  (bits_left),
    .pcm_out    (pcm_out),
    .ins_flag   (ins_flag),
    .del_flag   (del_flag)
);

// File: tb/sim_rx_slip_buffer.sv
module sim_rx_slip_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       slot_a = 1'b0;
    logic       slot_b = 1'b0;
    logic       slot_sel = 1'b1;
    logic       blank = 1'b0;
    logic       sup_n = 1'b1;
    logic       alarm = 1'b0;
    logic       pcm_out, ins_flag, del_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string tag = "R1";

    logic [7:0] pend_q[$];
    logic [7:0] last_b = 8'hFF;
    logic [7:0] sh = 8'hFF;
    int         left = 0;

    always #2 clk = ~clk;

    rx_slip_buffer u0 (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .slot_a(slot_a), .slot_b(slot_b), .slot_sel(slot_sel),
        .blank(blank), .sup_n(sup_n), .alarm(alarm),
        .pcm_out(pcm_out), .ins_flag(ins_flag), .del_flag(del_flag)
    );

    task automatic check(input string t, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, what, act, exp, $time);
        end
    endtask

    // one clock: model follows the inputs held at this edge, then compare
    task automatic tick();
        logic st, e_ins, e_del, e_pcm;
        logic [7:0] b;
        @(posedge clk);
        #1;
        st = slot_sel ? slot_a : slot_b;
        e_ins = 1'b0;
        e_del = 1'b0;
        if (st) begin
            if (pend_q.size() == 0) begin
                b = last_b;
                e_ins = 1'b1;
            end else begin
                b = pend_q[$];
                e_del = (pend_q.size() > 1);
            end
            last_b = b;
            pend_q.delete();
            sh = b;
            left = 8;
        end
        if (left > 0) begin
            e_pcm = sh[7];
            sh = sh << 1;
            left--;
        end else begin
            e_pcm = 1'b1;
        end
        if (blank || (!sup_n && alarm)) e_pcm = 1'b1;
        if (byte_vld) pend_q.push_back(byte_in);
        check(tag, "pcm_out", pcm_out, e_pcm);
        check(tag, "ins_flag", ins_flag, e_ins);
        check(tag, "del_flag", del_flag, e_del);
        byte_vld = 1'b0;
        slot_a = 1'b0;
        slot_b = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr(input logic [7:0] v);
        byte_vld = 1'b1;
        byte_in = v;
        tick();
    endtask

    task automatic slot(input logic use_a);
        if (use_a) slot_a = 1'b1;
        else       slot_b = 1'b1;
        tick();
        idle(10);
    endtask

    initial begin
        #9;
        tag = "R1";
        check("R1", "pcm_out in reset", pcm_out, 1'b1);
        check("R1", "ins_flag in reset", ins_flag, 1'b0);
        check("R1", "del_flag in reset", del_flag, 1'b0);
        rst_n = 1'b1;
        idle(3);
        slot(1'b1);                    // R1: 0xFF repeated with insertion

        tag = "R2";
        wr(8'hA5); idle(2); slot(1'b1);
        wr(8'h3C); idle(1); slot(1'b1);

        tag = "R4";
        slot(1'b1);                    // repeat 0x3C
        slot(1'b1);

        tag = "R5";
        wr(8'h12); wr(8'h5A); slot(1'b1);
        wr(8'h01); wr(8'h02); wr(8'hC3); slot(1'b1);

        tag = "R3";
        slot_sel = 1'b0;
        wr(8'h69);
        slot(1'b1);                    // unselected A: ignored
        slot(1'b0);                    // B reads 0x69
        wr(8'h96);
        slot_b = 1'b1; slot_sel = 1'b1; tick(); idle(10);   // B ignored when A selected
        slot(1'b1);                    // A reads 0x96

        tag = "R6";
        wr(8'h81);
        byte_vld = 1'b1; byte_in = 8'hE7; slot_a = 1'b1; tick(); idle(10);
        slot(1'b1);                    // E7 now

        tag = "R7";
        wr(8'h00);
        slot_a = 1'b1; tick();
        idle(2); blank = 1'b1; idle(3); blank = 1'b0; idle(8);

        tag = "R8";
        wr(8'h00);
        slot_a = 1'b1; tick();
        alarm = 1'b1; idle(3);          // supervision off: no effect
        sup_n = 1'b0; idle(3);
        alarm = 1'b0; idle(3);          // supervision alone: no effect
        sup_n = 1'b1; idle(4);

        tag = "R9";
        wr(8'h55); idle(20);
        slot(1'b1);
        idle(5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule